// File: doc/BRIEF.md
# Serial Display-RAM Write Decoder

This block sits behind a serial-peripheral slave shifter and converts the byte stream it delivers into single-cycle writes into an on-screen-display memory arranged as 16 rows by 32 columns. Every accepted byte is read either as a row address, a column address, or a display information byte, depending on its upper bits and on where the parser currently stands in a packet.

Three packet formats share one wire protocol. A host may send a row, a column and one information byte for each location. It may keep one row and send further column/information pairs for that row. It may also set a format flag in a column address to enter a streaming mode in which every later byte is data written at an address that advances on its own. Streaming is sticky: only dropping slave-select leaves it. Columns 24 to 29 are unused and are simply filled with dummy data during streaming. Columns 30 and 31 hold per-row control values and are written like any other column.

Top module: `osd_wr_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ram_we` is 0 and `ram_row`, `ram_col` and `ram_wdata` are all 0.
- R2: A byte accepted while a row is expected, with bit 7 = 1, is a row address. Its bits 3..0 appear on `ram_row` one cycle later. No write is issued, and the value holds until the next address byte.
- R3: A byte accepted while a column is expected, with bit 7 = 0, is a column address. Its bits 4..0 appear on `ram_col` one cycle later, the row is unchanged, and no write is issued.
- R4: The byte accepted right after a column address is an information byte, whatever its value. It causes `ram_we` = 1 for exactly one cycle, in the cycle after acceptance, with `ram_wdata` equal to the byte and `ram_row`/`ram_col` equal to the loaded address.
- R5: In the shared-row format, a column address (bit 7 = 0, bit 6 = 0) accepted after an information byte changes the column and keeps the row, and the next byte is written there.
- R6: A column address with bit 6 = 1 enters streaming. The first following byte is written at the loaded address, and each later byte is written at the previous write address plus one column.
- R7: In streaming, column 31 is followed by column 0 of the next row, and row 15 column 31 is followed by row 0 column 0.
- R8: Once streaming has begun, bytes with bit 7 = 1 or with the column format bit set are written as data and never taken as addresses, until slave-select drops.
- R9: Deasserting `spi_sel` returns the parser to expecting a row address and ends streaming. Bytes that are not row addresses arriving at that point produce no write.
- R10: A byte is accepted only in a cycle where both `byte_vld` and `spi_sel` are 1. Otherwise it changes no output and issues no write.
- R11: After an information byte in per-location or shared-row format, a row address (bit 7 = 1) is accepted, followed by a column and an information byte that is written at the new row and column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sel | input | 1 | Slave-select from the shifter, 1 while a transfer is open |
| byte_vld | input | 1 | One-cycle pulse marking a complete received byte |
| byte_in | input | 8 | Received byte, MSB first on the wire |
| ram_we | output | 1 | Display memory write strobe, one cycle per information byte |
| ram_row | output | 4 | Row of the last address byte or write |
| ram_col | output | 5 | Column of the last address byte or write |
| ram_wdata | output | 8 | Data for the write |

## Verification
Two events can coincide: a byte pulse arriving in the same cycle that slave-select drops, and a streaming write landing at row 15, column 31, where column and row wrap together. The bench raises `byte_vld` with `spi_sel` low while the block is streaming. It then checks that no write appears and that, after reselect, a plain data byte is ignored while a row byte is honoured. For the double wrap, it streams from row 15, column 31 and expects the next write at row 0, column 0.

// File: rtl/osd_wr_pkg.sv
package osd_wr_pkg;

    localparam int BYTE_W   = 8;
    localparam int ROW_W    = 4;
    localparam int COL_W    = 5;
    localparam int KIND_BIT = BYTE_W - 1;   // 1: row address
    localparam int FMT_BIT  = BYTE_W - 2;   // 1: streaming column
    localparam int ADDR_W   = ROW_W + COL_W;

    typedef enum logic [2:0] {
        PS_ROW,     // waiting for a row address
        PS_COL,     // row held, waiting for a column address
        PS_INFO,    // next byte is display information
        PS_ADDR,    // after information: row or column may follow
        PS_STREAM   // every byte is data, address self-advances
    } parse_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } osd_addr_t;

    typedef struct packed {
        logic              is_row;
        logic              is_col;
        logic              stream_req;
        logic [ROW_W-1:0]  row_num;
        logic [COL_W-1:0]  col_num;
    } byte_kind_t;

    // Row-major successor; packing row above column makes the carry
    // from column to row, and the row wrap, fall out of one adder.
    function automatic osd_addr_t addr_next(osd_addr_t a);
        logic [ADDR_W-1:0] flat;
        flat = a + ADDR_W'(1);
        return osd_addr_t'(flat);
    endfunction

endpackage

// File: rtl/osd_byte_class.sv
module osd_byte_class
    import osd_wr_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output byte_kind_t        kind_o
);
    logic unused_bits;
    assign unused_bits = ^byte_i[FMT_BIT-1:COL_W];

    always_comb begin
        kind_o            = '0;
        kind_o.is_row     = byte_i[KIND_BIT];
        kind_o.is_col     = ~byte_i[KIND_BIT];
        kind_o.stream_req = ~byte_i[KIND_BIT] & byte_i[FMT_BIT];
        kind_o.row_num    = byte_i[ROW_W-1:0];
        kind_o.col_num    = byte_i[COL_W-1:0];
    end
endmodule

// File: rtl/osd_fmt_fsm.sv
module osd_fmt_fsm
    import osd_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_i,
    input  logic       take_i,
    input  byte_kind_t kind_i,
    output logic       load_row_o,
    output logic       load_col_o,
    output logic       info_o,
    output logic       stream_o
);
    parse_e st_q;
    logic   stream_q;

    always_ff @(posedge clk) begin
        if (rst || !sel_i) begin
            st_q     <= PS_ROW;
            stream_q <= 1'b0;
        end else if (take_i) begin
            unique case (st_q)
                PS_ROW: begin
                    if (kind_i.is_row) st_q <= PS_COL;
                end
                PS_COL, PS_ADDR: begin
                    if (kind_i.is_row) begin
                        st_q <= PS_COL;
                    end else begin
                        st_q     <= PS_INFO;
                        stream_q <= kind_i.stream_req;
                    end
                end
                PS_INFO:   st_q <= stream_q ? PS_STREAM : PS_ADDR;
                PS_STREAM: st_q <= PS_STREAM;
                default:   st_q <= PS_ROW;
            endcase
        end
    end

    always_comb begin
        load_row_o = 1'b0;
        load_col_o = 1'b0;
        info_o     = 1'b0;
        if (take_i) begin
            unique case (st_q)
                PS_ROW:           load_row_o = kind_i.is_row;
                PS_COL, PS_ADDR: begin
                    load_row_o = kind_i.is_row;
                    load_col_o = kind_i.is_col;
                end
                PS_INFO, PS_STREAM: info_o = 1'b1;
                default: ;
            endcase
        end
    end

    assign stream_o = stream_q;
endmodule

// File: rtl/osd_addr_gen.sv
module osd_addr_gen
    import osd_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_row_i,
    input  logic             load_col_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             info_i,
    input  logic             stream_i,
    output osd_addr_t        cur_o
);
    osd_addr_t cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            if (load_row_i) cur_q.row <= row_i;
            if (load_col_i) cur_q.col <= col_i;
            if (info_i && stream_i) cur_q <= addr_next(cur_q);
        end
    end

    assign cur_o = cur_q;
endmodule

// File: rtl/osd_wr_decoder.sv
module osd_wr_decoder
    import osd_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sel,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              ram_we,
    output logic [ROW_W-1:0]  ram_row,
    output logic [COL_W-1:0]  ram_col,
    output logic [BYTE_W-1:0] ram_wdata
);
    byte_kind_t kind;
    osd_addr_t  cur;
    osd_addr_t  out_q;
    logic       take;
    logic       load_row;
    logic       load_col;
    logic       info;
    logic       stream_on;
    logic       we_q;
    logic [BYTE_W-1:0] data_q;

    assign take = byte_vld & spi_sel;

    osd_byte_class u_class (
        .byte_i (byte_in),
        .kind_o (kind)
    );

    osd_fmt_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sel_i      (spi_sel),
        .take_i     (take),
        .kind_i     (kind),
        .load_row_o (load_row),
        .load_col_o (load_col),
        .info_o     (info),
        .stream_o   (stream_on)
    );

    osd_addr_gen u_addr (
        .clk        (clk),
        .rst        (rst),
        .load_row_i (load_row),
        .load_col_i (load_col),
        .row_i      (kind.row_num),
        .col_i      (kind.col_num),
        .info_i     (info),
        .stream_i   (stream_on),
        .cur_o      (cur)
    );

    // Output stage: address follows address bytes and each write.
    always_ff @(posedge clk) begin
        if (rst) begin
            we_q   <= 1'b0;
            out_q  <= '0;
            data_q <= '0;
        end else begin
            we_q <= info;
            if (load_row) out_q.row <= kind.row_num;
            if (load_col) out_q.col <= kind.col_num;
            if (info) begin
                out_q  <= cur;
                data_q <= byte_in;
            end
        end
    end

    assign ram_we    = we_q;
    assign ram_row   = out_q.row;
    assign ram_col   = out_q.col;
    assign ram_wdata = data_q;
endmodule

// File: rtl/osd_wr_decoder_chk.sv
module osd_wr_decoder_chk
    import osd_wr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              spi_sel,
    input logic              byte_vld,
    input logic [BYTE_W-1:0] byte_in,
    input logic              ram_we,
    input logic [ROW_W-1:0]  ram_row,
    input logic [COL_W-1:0]  ram_col,
    input logic [BYTE_W-1:0] ram_wdata,
    input logic              stream_on
);
    logic              seen_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst || !stream_on) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (ram_we) begin
            seen_q <= 1'b1;
            last_q <= {ram_row, ram_col};
        end
    end

    assert_we_from_byte_R4: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(byte_vld && spi_sel));

    assert_data_capture_R4: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ram_wdata == $past(byte_in));

    assert_no_take_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(byte_vld && spi_sel) |-> !ram_we);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(byte_vld && spi_sel) |-> ($stable(ram_row) && $stable(ram_col)));

    assert_deselect_ends_stream_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!spi_sel) |-> !stream_on);

    assert_stream_step_R6: assert property (@(posedge clk) disable iff (rst)
        (ram_we && stream_on && seen_q) |-> ({ram_row, ram_col} == last_q + ADDR_W'(1)));
endmodule

bind osd_wr_decoder osd_wr_decoder_chk u_chk (.*);

// File: tb/sim_osd_wr_decoder.sv
module sim_osd_wr_decoder;
    localparam time TCK = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sel = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic       ram_we;
    logic [3:0] ram_row;
    logic [4:0] ram_col;
    logic [7:0] ram_wdata;

    int n_chk = 0;
    int n_bad = 0;

    always #(TCK/2) clk = ~clk;

    osd_wr_decoder u0 (
        .clk(clk), .rst(rst), .spi_sel(spi_sel), .byte_vld(byte_vld),
        .byte_in(byte_in), .ram_we(ram_we), .ram_row(ram_row),
        .ram_col(ram_col), .ram_wdata(ram_wdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one byte for one cycle; on return the outputs show its effect.
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic expect_wr(input string req, input int r, input int c, input logic [7:0] d);
        check(req, {ram_we, ram_row, ram_col, ram_wdata}, {1'b1, 4'(r), 5'(c), d});
    endtask

    task automatic expect_addr(input string req, input int r, input int c);
        check(req, {ram_we, ram_row, ram_col}, {1'b0, 4'(r), 5'(c)});
    endtask

    task automatic reselect();
        @(negedge clk); spi_sel = 1'b0;
        @(negedge clk); spi_sel = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 we", ram_we, 0);
        check("R1 row/col", {ram_row, ram_col}, 0);
        check("R1 data", ram_wdata, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {ram_we, ram_row, ram_col, ram_wdata}, 0);
    endtask

    task automatic t_per_location();
        reselect();
        send(8'h83); expect_addr("R2 row load", 3, 0);
        send(8'h05); expect_addr("R3 col load", 3, 5);
        send(8'hA5); expect_wr("R4 info write", 3, 5, 8'hA5);
        @(negedge clk); check("R4 single cycle strobe", ram_we, 0);
        check("R2 hold", {ram_row, ram_col}, {4'd3, 5'd5});
        send(8'h81); expect_addr("R11 row after info", 1, 5);
        send(8'h02); expect_addr("R11 col", 1, 2);
        send(8'hC3); expect_wr("R4 info with bit7 set", 1, 2, 8'hC3);
    endtask

    task automatic t_shared_row();
        reselect();
        send(8'h87); send(8'h0A);
        send(8'h11); expect_wr("R5 first", 7, 10, 8'h11);
        send(8'h1E); expect_addr("R5 col change keeps row", 7, 30);
        send(8'h22); expect_wr("R5 second write", 7, 30, 8'h22);
        send(8'h82); send(8'h01);
        send(8'h33); expect_wr("R11 back to per-location", 2, 1, 8'h33);
    endtask

    task automatic t_stream();
        reselect();
        send(8'h84);
        send(8'h5D); expect_addr("R6 stream col", 4, 29);
        send(8'h10); expect_wr("R6 first stream", 4, 29, 8'h10);
        send(8'h90); expect_wr("R8 row-like byte is data", 4, 30, 8'h90);
        send(8'h45); expect_wr("R8 stream-col byte is data", 4, 31, 8'h45);
        send(8'h01); expect_wr("R7 column wrap", 5, 0, 8'h01);
    endtask

    task automatic t_row_wrap();
        reselect();
        send(8'h8F); send(8'h5F);
        send(8'hAA); expect_wr("R7 last cell", 15, 31, 8'hAA);
        send(8'hBB); expect_wr("R7 row wrap", 0, 0, 8'hBB);
    endtask

    task automatic t_deselect();
        // still streaming from previous task; byte coincides with deselect
        @(negedge clk);
        spi_sel = 1'b0; byte_vld = 1'b1; byte_in = 8'h5A;
        @(negedge clk);
        byte_vld = 1'b0;
        check("R9/R10 byte during deselect", ram_we, 0);
        spi_sel = 1'b1;
        send(8'h12); expect_addr("R9 data before row ignored", 0, 0);
        send(8'h86); send(8'h03);
        send(8'h66); expect_wr("R9 plain format after reselect", 6, 3, 8'h66);
        send(8'h85); expect_addr("R9 streaming cleared", 5, 3);
    endtask

    task automatic t_ignored();
        @(negedge clk);
        byte_in = 8'h8A;
        @(negedge clk);
        expect_addr("R10 valid low ignored", 5, 3);
        send(8'h09); expect_addr("R10 parser unaffected", 5, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_per_location();
        t_shared_row();
        t_stream();
        t_row_wrap();
        t_deselect();
        t_ignored();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule